// File: doc/BRIEF.md
# Wide Mantissa Packer

This block reduces a 128-bit intermediate mantissa to a 64-bit result mantissa plus an 8-bit guard byte. The intermediate value is typically a full double-width product or a long quotient. It is built from four 32-bit words, and word 0 holds bits 127..96, the most significant. A 2-bit alignment code picks one of four fixed left shifts: 0, 1, 31 or 32 bit positions. After the shift, the top 64 bits form the mantissa and the next 8 bits form the guard byte. Every bit below the guard byte is ORed together into a sticky flag, and that flag is merged into guard bit 0, so a later rounding stage sees one byte that carries both guard and sticky information.

The upstream normalization logic presents the value and the alignment code together with a valid strobe. The packed result appears on registered outputs one clock later. The outputs keep their last value in cycles without a strobe.

Top module: `wpk_pack`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, mant_o and guard_o are zero and valid_o is low.
- R2: valid_o is high exactly in the cycle after a cycle in which valid_i was high at the rising clock edge.
- R3: With align_sel_i = 2'b00 (shift 0), mant_o = data_i[127:64] and guard_o[7:1] = data_i[63:57].
- R4: With align_sel_i = 2'b01 (shift 1), mant_o = data_i[126:63] and guard_o[7:1] = data_i[62:56].
- R5: With align_sel_i = 2'b10 (shift 31), mant_o = data_i[96:33] and guard_o[7:1] = data_i[32:26].
- R6: With align_sel_i = 2'b11 (shift 32), mant_o = data_i[95:32] and guard_o[7:1] = data_i[31:25].
- R7: guard_o[0] is the OR of the first guard bit and all bits below it: data_i[56:0] for shift 0, data_i[55:0] for shift 1, data_i[25:0] for shift 31 and data_i[24:0] for shift 32. No separate sticky output exists.
- R8: In a cycle with valid_i low, the values on data_i and align_sel_i have no effect, and mant_o and guard_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe |
| align_sel_i | input | 2 | Alignment code: 00 = shift 0, 01 = shift 1, 10 = shift 31, 11 = shift 32 |
| data_i | input | 128 | Intermediate mantissa; word 0 is bits 127..96 |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| mant_o | output | 64 | Packed mantissa |
| guard_o | output | 8 | Guard byte, with the sticky flag ORed into bit 0 |

## Verification
The strobe-delay property assumes that valid_i is low while reset is asserted. The bench therefore holds the strobe low until reset has been released for at least one cycle. The mapping properties assume that align_sel_i and data_i are stable at each rising edge where valid_i is high. The bench drives all inputs on the falling edge only. The stimulus also places single set bits exactly at the guard-to-sticky boundary of each alignment, and it changes data_i and align_sel_i during idle cycles to show that they are ignored.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
  localparam int WORD_W  = 32;
  localparam int N_WORDS = 4;
  localparam int TOTAL_W = WORD_W * N_WORDS;
  localparam int MANT_W  = 64;
  localparam int GUARD_W = 8;
  localparam int N_ALIGN = 4;
  localparam int SEL_W   = $clog2(N_ALIGN);

  typedef enum logic [SEL_W-1:0] {
    ALIGN_L0  = 2'b00,
    ALIGN_L1  = 2'b01,
    ALIGN_L31 = 2'b10,
    ALIGN_L32 = 2'b11
  } align_e;

  function automatic int shift_amt(int idx, int word_w);
    case (idx)
      0:       shift_amt = 0;
      1:       shift_amt = 1;
      2:       shift_amt = word_w - 1;
      default: shift_amt = word_w;
    endcase
  endfunction
endpackage

// File: rtl/wpk_align.sv
module wpk_align #(
  parameter int TOTAL_W = 128,
  parameter int MANT_W  = 64,
  parameter int GUARD_W = 8,
  parameter int SHIFT   = 0
) (
  input  logic [TOTAL_W-1:0]        data_i,
  output logic [MANT_W+GUARD_W-1:0] packed_o
);
  localparam int REST_W = TOTAL_W - MANT_W - GUARD_W;

  logic [TOTAL_W-1:0] shifted;
  logic               sticky;

  assign shifted = data_i << SHIFT;
  assign sticky  = |shifted[REST_W-1:0];

  assign packed_o = {shifted[TOTAL_W-1 -: MANT_W+GUARD_W-1],
                     shifted[REST_W] | sticky};
endmodule

// File: rtl/wpk_sel.sv
module wpk_sel #(
  parameter int N     = 4,
  parameter int W     = 72,
  parameter int SEL_W = $clog2(N)
) (
  input  logic [N-1:0][W-1:0] cand_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [W-1:0]        out_o
);
  always_comb begin
    out_o = '0;
    for (int k = 0; k < N; k++) begin
      if (sel_i == SEL_W'(k)) out_o = cand_i[k];
    end
  end
endmodule

// File: rtl/wpk_out_reg.sv
module wpk_out_reg #(
  parameter int W = 72
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/wpk_pack.sv
module wpk_pack
  import wpk_pkg::*;
#(
  parameter int P_TOTAL_W = TOTAL_W,
  parameter int P_MANT_W  = MANT_W,
  parameter int P_GUARD_W = GUARD_W,
  parameter int P_WORD_W  = WORD_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [SEL_W-1:0]     align_sel_i,
  input  logic [P_TOTAL_W-1:0] data_i,
  output logic                 valid_o,
  output logic [P_MANT_W-1:0]  mant_o,
  output logic [P_GUARD_W-1:0] guard_o
);
  localparam int PK_W = P_MANT_W + P_GUARD_W;

  logic [N_ALIGN-1:0][PK_W-1:0] cand;
  logic [PK_W-1:0]              picked;
  logic [PK_W-1:0]              held;

  for (genvar m = 0; m < N_ALIGN; m++) begin : g_align
    wpk_align #(
      .TOTAL_W(P_TOTAL_W),
      .MANT_W (P_MANT_W),
      .GUARD_W(P_GUARD_W),
      .SHIFT  (shift_amt(m, P_WORD_W))
    ) i_align (
      .data_i  (data_i),
      .packed_o(cand[m])
    );
  end

  wpk_sel #(.N(N_ALIGN), .W(PK_W), .SEL_W(SEL_W)) i_sel (
    .cand_i(cand),
    .sel_i (align_sel_i),
    .out_o (picked)
  );

  wpk_out_reg #(.W(PK_W)) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (valid_i),
    .d_i    (picked),
    .valid_o(valid_o),
    .q_o    (held)
  );

  assign mant_o  = held[PK_W-1 -: P_MANT_W];
  assign guard_o = held[P_GUARD_W-1:0];
endmodule

// File: rtl/wpk_pack_chk.sv
module wpk_pack_chk
  import wpk_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [SEL_W-1:0]   align_sel_i,
  input logic [TOTAL_W-1:0] data_i,
  input logic               valid_o,
  input logic [MANT_W-1:0]  mant_o,
  input logic [GUARD_W-1:0] guard_o
);
  localparam int REST_W = TOTAL_W - MANT_W - GUARD_W;

  assert_valid_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_l0_map_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && align_sel_i == ALIGN_L0) |=>
      (mant_o == $past(data_i[TOTAL_W-1 -: MANT_W])) &&
      (guard_o[GUARD_W-1:1] == $past(data_i[REST_W+GUARD_W-1 -: GUARD_W-1])));

  assert_l1_map_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && align_sel_i == ALIGN_L1) |=>
      (mant_o == $past(data_i[TOTAL_W-2 -: MANT_W])));

  assert_l31_map_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && align_sel_i == ALIGN_L31) |=>
      (mant_o == $past(data_i[TOTAL_W-WORD_W -: MANT_W])));

  assert_l32_map_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && align_sel_i == ALIGN_L32) |=>
      (mant_o == $past(data_i[TOTAL_W-WORD_W-1 -: MANT_W])));

  assert_sticky_l0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && align_sel_i == ALIGN_L0 && (|data_i[REST_W-1:0])) |=> guard_o[0]);

  assert_sticky_l32_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && align_sel_i == ALIGN_L32 && !(|data_i[REST_W-WORD_W:0])) |=> !guard_o[0]);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(mant_o) && $stable(guard_o));
endmodule

bind wpk_pack wpk_pack_chk i_wpk_pack_chk (.*);

// File: tb/test_wpk_pack.sv
`timescale 1ns/1ps
module test_wpk_pack;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   align_sel_i = 2'b00;
  logic [127:0] data_i = '0;
  logic         valid_o;
  logic [63:0]  mant_o;
  logic [7:0]   guard_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [63:0] exp_mant = '0;
  logic [7:0]  exp_guard = '0;
  logic        exp_valid = 1'b0;

  always #2.5 clk_i = ~clk_i;

  wpk_pack i_wpk_pack (.*);

  task automatic check(string tag);
    checks++;
    if (valid_o !== exp_valid || mant_o !== exp_mant || guard_o !== exp_guard) begin
      errors++;
      $display("FAIL %s: got v=%0b m=%h g=%h exp v=%0b m=%h g=%h", tag,
               valid_o, mant_o, guard_o, exp_valid, exp_mant, exp_guard);
    end
  endtask

  // Behavioural model: shift codes 00->0, 01->1, 10->31, 11->32.
  task automatic model(input logic [1:0] sel, input logic [127:0] d);
    int amt;
    logic [127:0] s;
    amt = (sel == 2'b00) ? 0 : (sel == 2'b01) ? 1 : (sel == 2'b10) ? 31 : 32;
    s = d << amt;
    exp_mant  = s[127:64];
    exp_guard = s[63:56];
    if (s[55:0] != 0) exp_guard[0] = 1'b1;
  endtask

  task automatic step(input logic v, input logic [1:0] sel,
                      input logic [127:0] d, input string tag);
    valid_i = v; align_sel_i = sel; data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    exp_valid = v;
    if (v) model(sel, d);
    check(tag);
  endtask

  function automatic string mode_tag(logic [1:0] s);
    case (s)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    logic [127:0] pat;
    @(negedge clk_i);
    check("R1 in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release");

    for (int s = 0; s < 4; s++) begin
      step(1'b1, 2'(s), {4{32'hFFFF_FFFF}}, mode_tag(2'(s)));
      step(1'b1, 2'(s), {4{32'hA5C3_0F96}}, mode_tag(2'(s)));
      step(1'b1, 2'(s), 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, mode_tag(2'(s)));
      for (int k = 0; k < 6; k++) begin
        pat = {$urandom(), $urandom(), $urandom(), $urandom()};
        step(1'b1, 2'(s), pat, mode_tag(2'(s)));
      end
    end

    // Sticky boundaries
    step(1'b1, 2'b00, 128'h1, "R7 l0 lsb");
    step(1'b1, 2'b00, 128'h0, "R7 l0 zero");
    step(1'b1, 2'b00, 128'h1 << 56, "R7 l0 guard bit");
    step(1'b1, 2'b01, 128'h1 << 55, "R7 l1 guard bit");
    step(1'b1, 2'b01, 128'h1 << 54, "R7 l1 sticky");
    step(1'b1, 2'b10, 128'h1 << 25, "R7 l31 guard bit");
    step(1'b1, 2'b10, 128'h1 << 24, "R7 l31 sticky");
    step(1'b1, 2'b11, 128'h1 << 24, "R7 l32 guard bit");
    step(1'b1, 2'b11, 128'h1 << 23, "R7 l32 sticky");
    step(1'b1, 2'b11, 128'h1 << 127, "R7 l32 top dropped");

    // Idle cycles with changing inputs
    step(1'b1, 2'b01, 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555, "R2 load");
    step(1'b0, 2'b11, {4{32'hFFFF_FFFF}}, "R8 idle");
    step(1'b0, 2'b00, '0, "R8 idle");
    step(1'b0, 2'b10, {4{32'h5555_AAAA}}, "R8 idle");
    step(1'b1, 2'b10, {4{32'h1357_9BDF}}, "R2 reload");
    step(1'b0, 2'b10, '0, "R2 drop");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule